// File: doc/BRIEF.md
# System Control Coprocessor Register File

This block sits next to a 32-bit processor core and answers its coprocessor register transfers. Each transfer names a primary register number, a secondary register number, two opcode fields, the core register that supplies or receives the data, and a direction. Reads return data combinationally in the cycle of the request. Writes update the register file on the next rising clock edge.

The file holds an identification constant, a control word, a translation-table base, a domain access word, a fault status byte and a fault address. The control bits drive dedicated enable outputs. Writes to the cache-maintenance and TLB-maintenance numbers do not store anything. Instead they issue one-cycle command pulses in the cycle after the accepting edge. Illegal or unsupported transfers raise an error flag in the request cycle and leave all state and commands untouched. An errored read returns zero.

Top module: `sysctl_regfile`

## Requirements
- R1: A transfer with a nonzero first opcode raises `acc_err` and returns zero read data. It changes no register and issues no command pulse.
- R2: A transfer whose core register index is 15 (the program counter) raises `acc_err` and has no effect.
- R3: Register number 0 reads as the constant `ID_VALUE` when the second opcode is 0. A write to it, or a read with a nonzero second opcode, raises `acc_err`.
- R4: Register number 1 is the control word. A legal write stores all 32 bits, and a read returns them. The bits drive these outputs: bit 0 drives `ctl_mmu_en`, bit 1 drives `ctl_align_chk`, bit 2 drives `ctl_dcache_en`, bit 3 drives `ctl_wbuf_en`, bit 7 drives `ctl_big_end`, and bit 12 drives `ctl_icache_en`.
- R5: A write to register 1 whose bit 7 differs from the stored bit 7 raises `unsup_err` and is discarded whole.
- R6: `mmu_changed` is high for exactly the cycle after a legal control write that flips bit 0.
- R7: Register number 2 keeps only bits 31..14 of the written value, and a read returns zeros in bits 13..0. A write with any of bits 13..0 set raises `align_warn` in the request cycle, and the write is still accepted.
- R8: Register number 5 keeps only bits 7..0. A read returns zero above bit 7.
- R9: Register numbers 3 and 6 are plain 32-bit read/write registers.
- R10: Register numbers 7 and 8 are write-only, and reading either raises `acc_err`. A legal write to 7 gives `cache_op_pulse` in the next cycle.
- R11: A legal write to 8 with second opcode 0 gives `tlb_inv_all` in the next cycle. With any other second opcode it gives `tlb_inv_addr`, with `tlb_inv_va` equal to the written data. At most one command pulse is high in any cycle.
- R12: Register number 13 reads as zero. An access with a nonzero second opcode or secondary number raises `acc_err`. Writing a nonzero value raises `unsup_err`.
- R13: Register numbers 9 and 15 accept writes without error and without effect, and they read as zero. Register numbers 4, 10, 11, 12 and 14 raise `acc_err` on any access.
- R14: Synchronous reset clears every stored register and every output. With `req_valid` low, `rd_data` is zero and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A transfer is presented this cycle |
| req_read | input | 1 | 1 = move from register file to core, 0 = move to register file |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary register number |
| req_op1 | input | 3 | First opcode field |
| req_op2 | input | 3 | Second opcode field |
| req_rd | input | 4 | Core register index of the transfer |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, same cycle |
| acc_err | output | 1 | Illegal access in this cycle |
| unsup_err | output | 1 | Unsupported feature requested in this cycle |
| align_warn | output | 1 | Translation base written with low bits set |
| cache_op_pulse | output | 1 | Cache-maintenance command |
| tlb_inv_all | output | 1 | Invalidate all translations |
| tlb_inv_addr | output | 1 | Invalidate one translation |
| tlb_inv_va | output | 32 | Address for `tlb_inv_addr` |
| ctl_mmu_en | output | 1 | Control bit 0 |
| ctl_align_chk | output | 1 | Control bit 1 |
| ctl_dcache_en | output | 1 | Control bit 2 |
| ctl_wbuf_en | output | 1 | Control bit 3 |
| ctl_big_end | output | 1 | Control bit 7 |
| ctl_icache_en | output | 1 | Control bit 12 |
| mmu_changed | output | 1 | Control bit 0 toggled at the last edge |

## Verification
Directed transfers come first. They cover each register number with both directions, writes to the translation base with and without low bits set, a control write that toggles bit 0 against one that leaves it alone, an attempt to flip bit 7, and TLB writes with second opcode 0 against nonzero. Long random runs follow. They mix all sixteen register numbers with occasional nonzero first opcodes, program-counter transfers and nonzero secondary fields. Each of these illegal fields must be rejected on its own, while the neighbouring legal traffic keeps updating state. A bench-side model predicts the flags, the read data, the control outputs and the command pulses.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int XLEN   = 32;
  localparam int NUM_W  = 4;
  localparam int OPC_W  = 3;
  localparam int IDX_W  = 4;

  localparam logic [IDX_W-1:0] PC_INDEX = 4'd15;

  // register numbers whose behaviour depends on the number
  localparam logic [NUM_W-1:0] RN_IDENT  = 4'd0;
  localparam logic [NUM_W-1:0] RN_CTRL   = 4'd1;
  localparam logic [NUM_W-1:0] RN_XLBASE = 4'd2;
  localparam logic [NUM_W-1:0] RN_DOMAIN = 4'd3;
  localparam logic [NUM_W-1:0] RN_FSTAT  = 4'd5;
  localparam logic [NUM_W-1:0] RN_FADDR  = 4'd6;
  localparam logic [NUM_W-1:0] RN_CACHE  = 4'd7;
  localparam logic [NUM_W-1:0] RN_TLB    = 4'd8;
  localparam logic [NUM_W-1:0] RN_LOCK   = 4'd9;
  localparam logic [NUM_W-1:0] RN_CTXID  = 4'd13;
  localparam logic [NUM_W-1:0] RN_IMPDEF = 4'd15;

  // control word bit positions
  localparam int CB_MMU   = 0;
  localparam int CB_ALIGN = 1;
  localparam int CB_DC    = 2;
  localparam int CB_WB    = 3;
  localparam int CB_BIG   = 7;
  localparam int CB_IC    = 12;

  typedef struct packed {
    logic ctrl;
    logic xlbase;
    logic domain;
    logic fstat;
    logic faddr;
    logic cache_cmd;
    logic tlb_all;
    logic tlb_one;
  } wr_sel_t;

  // clear every bit below position lsb
  function automatic logic [XLEN-1:0] keep_above(input logic [XLEN-1:0] v, input int lsb);
    logic [XLEN-1:0] low_mask;
    low_mask = (XLEN'(1) << lsb) - XLEN'(1);
    return v & ~low_mask;
  endfunction

  // keep only the lowest w bits
  function automatic logic [XLEN-1:0] keep_below(input logic [XLEN-1:0] v, input int w);
    logic [XLEN-1:0] low_mask;
    low_mask = (XLEN'(1) << w) - XLEN'(1);
    return v & low_mask;
  endfunction

  // any bit set below position lsb
  function automatic logic low_bits_set(input logic [XLEN-1:0] v, input int lsb);
    return keep_below(v, lsb) != '0;
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int TTB_LSB = 14
) (
  input  logic             valid,
  input  logic             rd_dir,
  input  logic [NUM_W-1:0] crn,
  input  logic [NUM_W-1:0] crm,
  input  logic [OPC_W-1:0] op1,
  input  logic [OPC_W-1:0] op2,
  input  logic [IDX_W-1:0] ridx,
  input  logic [XLEN-1:0]  wdata,
  input  logic             cur_big,
  output logic             acc_err,
  output logic             unsup_err,
  output logic             warn,
  output logic             read_ok,
  output wr_sel_t          wsel
);
  logic illegal;
  logic unsup;
  logic ok;
  wr_sel_t raw_sel;

  always_comb begin
    illegal = (op1 != '0) || (ridx == PC_INDEX);
    unsup   = 1'b0;
    raw_sel = '0;
    unique case (crn)
      RN_IDENT:  illegal = illegal || !rd_dir || (op2 != '0);
      RN_CTRL: begin
        unsup        = !rd_dir && (wdata[CB_BIG] != cur_big);
        raw_sel.ctrl = 1'b1;
      end
      RN_XLBASE: raw_sel.xlbase = 1'b1;
      RN_DOMAIN: raw_sel.domain = 1'b1;
      RN_FSTAT:  raw_sel.fstat  = 1'b1;
      RN_FADDR:  raw_sel.faddr  = 1'b1;
      RN_CACHE: begin
        illegal           = illegal || rd_dir;
        raw_sel.cache_cmd = 1'b1;
      end
      RN_TLB: begin
        illegal         = illegal || rd_dir;
        raw_sel.tlb_all = (op2 == '0);
        raw_sel.tlb_one = (op2 != '0);
      end
      RN_LOCK, RN_IMPDEF: ;
      RN_CTXID: begin
        illegal = illegal || (op2 != '0) || (crm != '0);
        unsup   = !rd_dir && (wdata != '0);
      end
      default:   illegal = 1'b1;
    endcase
  end

  assign acc_err   = valid && illegal;
  assign unsup_err = valid && !illegal && unsup;
  assign ok        = valid && !illegal && !unsup;
  assign read_ok   = ok && rd_dir;
  assign wsel      = (ok && !rd_dir) ? raw_sel : '0;
  assign warn      = valid && !illegal && !rd_dir && (crn == RN_XLBASE) &&
                     low_bits_set(wdata, TTB_LSB);
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter logic [XLEN-1:0] ID_VALUE = 32'h5C0D_0042,
  parameter int              TTB_LSB  = 14,
  parameter int              FSR_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  wr_sel_t          wsel,
  input  logic [XLEN-1:0]  wdata,
  input  logic             read_ok,
  input  logic [NUM_W-1:0] crn,
  output logic [XLEN-1:0]  rd_data,
  output logic [XLEN-1:0]  ctrl_q,
  output logic             mmu_chg
);
  logic [XLEN-1:0] xlbase_q, domain_q, fstat_q, faddr_q;
  logic            mmu_flip;

  assign mmu_flip = wsel.ctrl && (wdata[CB_MMU] != ctrl_q[CB_MMU]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      xlbase_q <= '0;
      domain_q <= '0;
      fstat_q  <= '0;
      faddr_q  <= '0;
      mmu_chg  <= 1'b0;
    end else begin
      mmu_chg <= mmu_flip;
      if (wsel.ctrl)   ctrl_q   <= wdata;
      if (wsel.xlbase) xlbase_q <= keep_above(wdata, TTB_LSB);
      if (wsel.domain) domain_q <= wdata;
      if (wsel.fstat)  fstat_q  <= keep_below(wdata, FSR_W);
      if (wsel.faddr)  faddr_q  <= wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    if (read_ok) begin
      unique case (crn)
        RN_IDENT:  rd_data = ID_VALUE;
        RN_CTRL:   rd_data = ctrl_q;
        RN_XLBASE: rd_data = keep_above(xlbase_q, TTB_LSB);
        RN_DOMAIN: rd_data = domain_q;
        RN_FSTAT:  rd_data = keep_below(fstat_q, FSR_W);
        RN_FADDR:  rd_data = faddr_q;
        default:   rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
  import sysctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  wr_sel_t         wsel,
  input  logic [XLEN-1:0] wdata,
  output logic            cache_op,
  output logic            inv_all,
  output logic            inv_one,
  output logic [XLEN-1:0] inv_va
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cache_op <= 1'b0;
      inv_all  <= 1'b0;
      inv_one  <= 1'b0;
      inv_va   <= '0;
    end else begin
      cache_op <= wsel.cache_cmd;
      inv_all  <= wsel.tlb_all;
      inv_one  <= wsel.tlb_one;
      inv_va   <= wsel.tlb_one ? wdata : '0;
    end
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h5C0D_0042,
  parameter int          TTB_LSB  = 14,
  parameter int          FSR_W    = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_read,
  input  logic [3:0]  req_crn,
  input  logic [3:0]  req_crm,
  input  logic [2:0]  req_op1,
  input  logic [2:0]  req_op2,
  input  logic [3:0]  req_rd,
  input  logic [31:0] req_wdata,
  output logic [31:0] rd_data,
  output logic        acc_err,
  output logic        unsup_err,
  output logic        align_warn,
  output logic        cache_op_pulse,
  output logic        tlb_inv_all,
  output logic        tlb_inv_addr,
  output logic [31:0] tlb_inv_va,
  output logic        ctl_mmu_en,
  output logic        ctl_align_chk,
  output logic        ctl_dcache_en,
  output logic        ctl_wbuf_en,
  output logic        ctl_big_end,
  output logic        ctl_icache_en,
  output logic        mmu_changed
);
  wr_sel_t         wr_sel;
  logic            read_ok;
  logic [XLEN-1:0] ctrl_word;

  sysctl_decode #(.TTB_LSB(TTB_LSB)) u_decode (
    .valid     (req_valid),
    .rd_dir    (req_read),
    .crn       (req_crn),
    .crm       (req_crm),
    .op1       (req_op1),
    .op2       (req_op2),
    .ridx      (req_rd),
    .wdata     (req_wdata),
    .cur_big   (ctrl_word[CB_BIG]),
    .acc_err   (acc_err),
    .unsup_err (unsup_err),
    .warn      (align_warn),
    .read_ok   (read_ok),
    .wsel      (wr_sel)
  );

  sysctl_regs #(.ID_VALUE(ID_VALUE), .TTB_LSB(TTB_LSB), .FSR_W(FSR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wsel    (wr_sel),
    .wdata   (req_wdata),
    .read_ok (read_ok),
    .crn     (req_crn),
    .rd_data (rd_data),
    .ctrl_q  (ctrl_word),
    .mmu_chg (mmu_changed)
  );

  sysctl_cmd u_cmd (
    .clk      (clk),
    .rst      (rst),
    .wsel     (wr_sel),
    .wdata    (req_wdata),
    .cache_op (cache_op_pulse),
    .inv_all  (tlb_inv_all),
    .inv_one  (tlb_inv_addr),
    .inv_va   (tlb_inv_va)
  );

  assign ctl_mmu_en    = ctrl_word[CB_MMU];
  assign ctl_align_chk = ctrl_word[CB_ALIGN];
  assign ctl_dcache_en = ctrl_word[CB_DC];
  assign ctl_wbuf_en   = ctrl_word[CB_WB];
  assign ctl_big_end   = ctrl_word[CB_BIG];
  assign ctl_icache_en = ctrl_word[CB_IC];
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
  parameter int TTB_LSB = 14,
  parameter int FSR_W   = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_read,
  input logic [3:0]  req_crn,
  input logic [2:0]  req_op1,
  input logic [3:0]  req_rd,
  input logic [31:0] rd_data,
  input logic        acc_err,
  input logic        cache_op_pulse,
  input logic        tlb_inv_all,
  input logic        tlb_inv_addr,
  input logic        ctl_mmu_en,
  input logic        ctl_align_chk,
  input logic        ctl_dcache_en,
  input logic        ctl_wbuf_en,
  input logic        ctl_big_end,
  input logic        ctl_icache_en,
  input logic        mmu_changed
);
  logic [5:0] ctl_vec;
  assign ctl_vec = {ctl_icache_en, ctl_big_end, ctl_wbuf_en, ctl_dcache_en, ctl_align_chk, ctl_mmu_en};

  // R1
  op1_flag_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op1 != 3'd0 |-> acc_err && rd_data == 32'd0);

  // R1
  op1_inert_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op1 != 3'd0 |=> $stable(ctl_vec) && !cache_op_pulse && !tlb_inv_all && !tlb_inv_addr);

  // R2
  pc_flag_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_rd == 4'd15 |-> acc_err);

  // R5
  big_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(ctl_big_end));

  // R6
  mmu_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    mmu_changed |-> ctl_mmu_en != $past(ctl_mmu_en));

  // R7
  base_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_read && req_crn == 4'd2 && !acc_err |-> (rd_data & ((32'd1 << TTB_LSB) - 32'd1)) == 32'd0);

  // R8
  fstat_width_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_read && req_crn == 4'd5 |-> (rd_data >> FSR_W) == 32'd0);

  // R10
  cmd_read_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_read && (req_crn == 4'd7 || req_crn == 4'd8) |-> acc_err);

  // R11
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cache_op_pulse, tlb_inv_all, tlb_inv_addr}));
endmodule

bind sysctl_regfile sysctl_regfile_chk #(.TTB_LSB(TTB_LSB), .FSR_W(FSR_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_read       (req_read),
  .req_crn        (req_crn),
  .req_op1        (req_op1),
  .req_rd         (req_rd),
  .rd_data        (rd_data),
  .acc_err        (acc_err),
  .cache_op_pulse (cache_op_pulse),
  .tlb_inv_all    (tlb_inv_all),
  .tlb_inv_addr   (tlb_inv_addr),
  .ctl_mmu_en     (ctl_mmu_en),
  .ctl_align_chk  (ctl_align_chk),
  .ctl_dcache_en  (ctl_dcache_en),
  .ctl_wbuf_en    (ctl_wbuf_en),
  .ctl_big_end    (ctl_big_end),
  .ctl_icache_en  (ctl_icache_en),
  .mmu_changed    (mmu_changed)
);

// File: tb/sysctl_regfile_tb.sv
module sysctl_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IDV = 32'h5C0D_0042;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_read = 1'b0;
  logic [3:0] req_crn = '0, req_crm = '0, req_rd = '0;
  logic [2:0] req_op1 = '0, req_op2 = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data, tlb_inv_va;
  logic acc_err, unsup_err, align_warn, cache_op_pulse, tlb_inv_all, tlb_inv_addr;
  logic ctl_mmu_en, ctl_align_chk, ctl_dcache_en, ctl_wbuf_en, ctl_big_end, ctl_icache_en, mmu_changed;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] m_ctrl = 0, m_base = 0, m_dom = 0, m_fst = 0, m_fad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regfile u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_read(req_read),
    .req_crn(req_crn), .req_crm(req_crm), .req_op1(req_op1), .req_op2(req_op2),
    .req_rd(req_rd), .req_wdata(req_wdata), .rd_data(rd_data), .acc_err(acc_err),
    .unsup_err(unsup_err), .align_warn(align_warn), .cache_op_pulse(cache_op_pulse),
    .tlb_inv_all(tlb_inv_all), .tlb_inv_addr(tlb_inv_addr), .tlb_inv_va(tlb_inv_va),
    .ctl_mmu_en(ctl_mmu_en), .ctl_align_chk(ctl_align_chk), .ctl_dcache_en(ctl_dcache_en),
    .ctl_wbuf_en(ctl_wbuf_en), .ctl_big_end(ctl_big_end), .ctl_icache_en(ctl_icache_en),
    .mmu_changed(mmu_changed)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string req_tag(input logic [3:0] crn, input logic [2:0] op1, input logic [3:0] ridx);
    if (op1 != 0) return "R1";
    if (ridx == 15) return "R2";
    case (crn)
      0: return "R3";
      1: return "R4";
      2: return "R7";
      5: return "R8";
      3, 6: return "R9";
      7: return "R10";
      8: return "R11";
      13: return "R12";
      default: return "R13";
    endcase
  endfunction

  function automatic logic [5:0] ctl_pick(input logic [31:0] c);
    return {c[12], c[7], c[3], c[2], c[1], c[0]};
  endfunction

  task automatic access(input bit rdir, input logic [3:0] crn, input logic [3:0] crm,
                        input logic [2:0] op1, input logic [2:0] op2,
                        input logic [3:0] ridx, input logic [31:0] wd);
    bit acc, uns, good, warn, e_cache, e_all, e_one, e_mmu;
    logic [31:0] e_rd, e_va;
    string tg;
    tg = req_tag(crn, op1, ridx);
    acc = (op1 != 0) || (ridx == 15);
    case (crn)
      0: if (!rdir || op2 != 0) acc = 1;
      7, 8: if (rdir) acc = 1;
      13: if (op2 != 0 || crm != 0) acc = 1;
      4, 10, 11, 12, 14: acc = 1;
      default: ;
    endcase
    uns = 0;
    if (!acc && !rdir && crn == 1 && wd[7] != m_ctrl[7]) begin uns = 1; tg = "R5"; end
    if (!acc && !rdir && crn == 13 && wd != 0) uns = 1;
    good = !acc && !uns;
    warn = !acc && !rdir && crn == 2 && wd[13:0] != 0;
    e_rd = 0;
    if (good && rdir)
      case (crn)
        0: e_rd = IDV;
        1: e_rd = m_ctrl;
        2: e_rd = m_base;
        3: e_rd = m_dom;
        5: e_rd = m_fst;
        6: e_rd = m_fad;
        default: e_rd = 0;
      endcase
    e_cache = 0; e_all = 0; e_one = 0; e_mmu = 0; e_va = 0;
    @(negedge clk);
    req_valid = 1; req_read = rdir; req_crn = crn; req_crm = crm;
    req_op1 = op1; req_op2 = op2; req_rd = ridx; req_wdata = wd;
    #1;
    chk(tg, "acc_err", 32'(acc_err), 32'(acc));
    chk(tg, "unsup_err", 32'(unsup_err), 32'(uns));
    chk(tg, "align_warn", 32'(align_warn), 32'(warn));
    chk(tg, "rd_data", rd_data, e_rd);
    if (good && !rdir)
      case (crn)
        1: begin e_mmu = wd[0] != m_ctrl[0]; m_ctrl = wd; end
        2: m_base = {wd[31:14], 14'd0};
        3: m_dom = wd;
        5: m_fst = {24'd0, wd[7:0]};
        6: m_fad = wd;
        7: e_cache = 1;
        8: if (op2 == 0) e_all = 1; else begin e_one = 1; e_va = wd; end
        default: ;
      endcase
    @(posedge clk);
    #1;
    req_valid = 0;
    chk(tg, "ctl outputs (R4)", 32'({ctl_icache_en, ctl_big_end, ctl_wbuf_en, ctl_dcache_en, ctl_align_chk, ctl_mmu_en}),
        32'(ctl_pick(m_ctrl)));
    chk("R6", "mmu_changed", 32'(mmu_changed), 32'(e_mmu));
    chk("R10", "cache_op_pulse", 32'(cache_op_pulse), 32'(e_cache));
    chk("R11", "tlb_inv_all", 32'(tlb_inv_all), 32'(e_all));
    chk("R11", "tlb_inv_addr", 32'(tlb_inv_addr), 32'(e_one));
    if (e_one) chk("R11", "tlb_inv_va", tlb_inv_va, e_va);
  endtask

  task automatic rd(input logic [3:0] crn);
    access(1, crn, 0, 0, 0, 4'd2, 32'd0);
  endtask

  task automatic wr(input logic [3:0] crn, input logic [2:0] op2, input logic [31:0] wd);
    access(0, crn, 0, 0, op2, 4'd3, wd);
  endtask

  initial begin
    repeat (CLK_PERIOD * 150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1337));
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    // R14: reset state and idle behaviour
    chk("R14", "ctl after reset", 32'({ctl_icache_en, ctl_big_end, ctl_wbuf_en, ctl_dcache_en, ctl_align_chk, ctl_mmu_en}), 0);
    chk("R14", "pulses after reset", 32'({cache_op_pulse, tlb_inv_all, tlb_inv_addr, mmu_changed}), 0);
    chk("R14", "idle rd_data", rd_data, 0);
    chk("R14", "idle flags", 32'({acc_err, unsup_err, align_warn}), 0);
    rd(1); rd(2); rd(3); rd(5); rd(6);
    // R3 identification
    rd(0);
    access(1, 0, 0, 0, 3'd1, 4'd2, 0);
    wr(0, 0, 32'hFFFF_FFFF);
    // R4 R6 control
    wr(1, 0, 32'h0000_100F);
    wr(1, 0, 32'h0000_100F);
    wr(1, 0, 32'h0000_0006);
    rd(1);
    // R5 big-endian flip rejected
    wr(1, 0, 32'h0000_0081);
    rd(1);
    // R7 base alignment
    wr(2, 0, 32'h1234_5678);
    rd(2);
    wr(2, 0, 32'hABCD_C000);
    rd(2);
    // R8 R9
    wr(5, 0, 32'hDEAD_BEEF); rd(5);
    wr(3, 0, 32'h5555_AAAA); rd(3);
    wr(6, 0, 32'h8765_4321); rd(6);
    // R10 R11 commands
    wr(7, 0, 32'h1); rd(7);
    wr(8, 0, 32'h0);
    wr(8, 3'd1, 32'hC001_0000); rd(8);
    // R12 context id
    wr(13, 0, 32'h0); wr(13, 0, 32'h7); rd(13);
    access(1, 13, 4'd1, 0, 0, 4'd2, 0);
    // R13 accepted-no-effect and unimplemented numbers
    wr(9, 0, 32'hFFFF_FFFF); wr(15, 0, 32'h1234); rd(9); rd(4); wr(11, 0, 1);
    // R1 R2 illegal fields on an otherwise legal control write
    access(0, 1, 0, 3'd2, 0, 4'd3, 32'h0000_0001);
    access(0, 1, 0, 0, 0, 4'd15, 32'h0000_0001);
    rd(1);
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] crn, crm, ridx;
      logic [2:0] op1, op2;
      logic [31:0] wd;
      bit rdir;
      crn  = 4'($urandom % 16);
      crm  = ($urandom % 6 == 0) ? 4'($urandom % 16) : 4'd0;
      op1  = ($urandom % 8 == 0) ? 3'(1 + $urandom % 7) : 3'd0;
      op2  = ($urandom % 3 == 0) ? 3'($urandom % 8) : 3'd0;
      ridx = ($urandom % 10 == 0) ? 4'd15 : 4'($urandom % 15);
      rdir = 1'($urandom % 2);
      wd   = $urandom;
      if (crn == 1 && ($urandom % 4 != 0)) wd[7] = m_ctrl[7];
      if (crn == 13 && ($urandom % 2 == 0)) wd = 0;
      access(rdir, crn, crm, op1, op2, ridx, wd);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule